// File: doc/BRIEF.md
# Conversion Averaging and Window Compare Unit

This unit sits behind an analog-to-digital conversion engine and turns a run of raw conversions into one stored result. A command is launched with a start pulse, which latches the averaging code, the sample-time code, the compare mode and the two 16-bit window limits. For every conversion the unit first drives a sample phase whose length comes from the sample-time code. It then waits for the engine's conversion-done strobe and adds the raw value into an internal accumulator. Once 2^n conversions have been collected, it forms the average.

The average then passes through an optional window compare. Depending on the latched mode, the unit stores every result, stores only in-window results, or throws away out-of-window results and requests a fresh acquisition of the same channel until a result falls inside the window. An abort input cancels a command at any point and leaves the unit idle with a cleared accumulator.

Top module: `avg_window_unit`

## Requirements
- R1: An averaging code n (0 to 7) makes a command collect exactly 2^n accepted conversions before its result is evaluated; no command-done pulse appears before the last one.
- R2: The evaluated result is the sum of the 2^n raw values shifted right by n, truncated with no rounding and with no internal wrap for 16-bit inputs; partial sums never produce a store.
- R3: With compare mode 2'b00, every evaluated result is stored: a one-cycle store_vld carrying store_data and a one-cycle cmd_done appear in the same cycle.
- R4: With compare mode 2'b10, the result is stored only when lim_lo <= result <= lim_hi (unsigned, both bounds inclusive); cmd_done pulses whether or not a store happens.
- R5: With compare mode 2'b11, an out-of-window result gives a one-cycle reacq_req with neither a store nor cmd_done, clears the accumulator and starts a new full acquisition; an in-window result is stored together with cmd_done.
- R6: Compare mode 2'b01 behaves as mode 2'b00 (stores every result).
- R7: Each conversion is preceded by a sample_phase high for 3, 5, 7, 11, 19, 35, 67 or 131 consecutive cycles for sample-time codes 0 to 7 respectively.
- R8: abort cancels the command at once: sample_phase drops on the next cycle, no store, reacq_req or cmd_done follows, and the next command starts from an empty accumulator.
- R9: conv_done is accepted only after a sample phase ends, while the unit waits for a conversion; strobes during a sample phase or while idle have no effect on the result or the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a command when idle; latches the settings below |
| abort | input | 1 | Cancel the running command and clear the accumulator |
| avg_code | input | 3 | Averaging code n, 2^n conversions |
| stime_code | input | 3 | Sample-time code |
| cmp_mode | input | 2 | 00 off, 01 treated as off, 10 store-if-in-window, 11 retry-until-in-window |
| lim_lo | input | 16 | Lower window limit (inclusive) |
| lim_hi | input | 16 | Upper window limit (inclusive) |
| conv_done | input | 1 | Conversion-complete strobe from the engine |
| conv_data | input | 16 | Raw conversion value, valid with conv_done |
| sample_phase | output | 1 | High while the input is being sampled |
| store_vld | output | 1 | One-cycle strobe: store_data is a result to keep |
| store_data | output | 16 | Averaged result |
| reacq_req | output | 1 | One-cycle request: result rejected, acquisition restarted |
| cmd_done | output | 1 | One-cycle pulse: command finished |

## Verification
Several properties are checked on every cycle. Every store made in a filtering or retrying mode must lie inside the latched window. A retry request never coincides with a store or with command completion. Abort silences all outputs on the next cycle. The accumulator never shrinks while adding, and the sample counter steps down by one per cycle. The arithmetic and the counting are left to the bench's directed scenarios: the averaged values, including the 128-sample case near full scale, the number of conversions per command, the sample-phase lengths, the inclusive window edges, the reserved mode code and the strobes that must be ignored.

// File: rtl/avgw_pkg.sv
package avgw_pkg;

  typedef enum logic [1:0] {
    CMP_OFF    = 2'b00,
    CMP_RSV    = 2'b01,
    CMP_FILTER = 2'b10,
    CMP_RETRY  = 2'b11
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_WAIT,
    ST_EVAL
  } fsm_e;

  // Sample-phase length in clock cycles: 3 for code 0, else 2^code + 3.
  function automatic int unsigned stime_cycles(input int unsigned code);
    return (code == 0) ? 3 : ((32'd1 << code) + 32'd3);
  endfunction

endpackage

// File: rtl/avgw_sample_timer.sv
module avgw_sample_timer #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              stop,
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic              last_cycle
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (stop)     cnt <= '0;
    else if (load)     cnt <= CNT_W'(avgw_pkg::stime_cycles(32'(code)));
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign active     = (cnt != '0);
  assign last_cycle = (cnt == CNT_W'(1));

  // R7: the phase counter steps down one per cycle until it expires
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    active && !load && !stop |=> cnt == $past(cnt) - 1'b1);
  // R7: a load that is not cancelled opens a sample phase
  a_r7_load_opens: assert property (@(posedge clk) disable iff (!rst_n)
    load && !stop |=> active);
endmodule

// File: rtl/avgw_accum.sv
module avgw_accum #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3,
  localparam int MAX_LOG = (1 << CODE_W) - 1,
  localparam int ACC_W   = DATA_W + MAX_LOG,
  localparam int IT_W    = MAX_LOG + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [DATA_W-1:0] din,
  input  logic [CODE_W-1:0] code,
  output logic              is_last,
  output logic [DATA_W-1:0] avg_out
);
  logic [ACC_W-1:0] acc;
  logic [IT_W-1:0]  iter;
  logic [IT_W-1:0]  limit;

  function automatic logic [DATA_W-1:0] shift_avg(input logic [ACC_W-1:0] sum,
                                                  input logic [CODE_W-1:0] n);
    logic [ACC_W-1:0] sh;
    sh = sum >> n;
    return sh[DATA_W-1:0];
  endfunction

  assign limit   = (IT_W'(1) << code) - IT_W'(1);
  assign is_last = (iter == limit);
  assign avg_out = shift_avg(acc, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      iter <= '0;
    end else if (clr) begin
      acc  <= '0;
      iter <= '0;
    end else if (add_en) begin
      acc <= acc + ACC_W'(din);
      if (!is_last) iter <= iter + 1'b1;
    end
  end

  // R2: adding never wraps the accumulator
  a_r2_acc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && !clr |=> acc >= $past(acc));
  // R1: the iteration index never passes the last of the 2^n conversions
  a_r1_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    iter <= limit);
endmodule

// File: rtl/avgw_window.sv
module avgw_window #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              hit
);
  function automatic logic in_window(input logic [DATA_W-1:0] v,
                                     input logic [DATA_W-1:0] l,
                                     input logic [DATA_W-1:0] h);
    return (v >= l) && (v <= h);
  endfunction

  assign hit = in_window(value, lo, hi);
endmodule

// File: rtl/avg_window_unit.sv
module avg_window_unit #(
  parameter int DATA_W  = 16,
  parameter int AVG_W   = 3,
  parameter int STIME_W = 3,
  parameter int TCNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic [AVG_W-1:0]   avg_code,
  input  logic [STIME_W-1:0] stime_code,
  input  logic [1:0]         cmp_mode,
  input  logic [DATA_W-1:0]  lim_lo,
  input  logic [DATA_W-1:0]  lim_hi,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  output logic               sample_phase,
  output logic               store_vld,
  output logic [DATA_W-1:0]  store_data,
  output logic               reacq_req,
  output logic               cmd_done
);
  import avgw_pkg::*;

  fsm_e               state;
  logic [AVG_W-1:0]   avg_q;
  logic [STIME_W-1:0] st_q;
  cmp_mode_e          mode_q;
  logic [DATA_W-1:0]  lo_q, hi_q;

  // named internal events
  logic start_ok, accept, next_iter, retry_go, do_store, finish;
  logic tmr_load, tmr_last, acc_clr, is_last, hit;
  logic [STIME_W-1:0] tmr_code;
  logic [DATA_W-1:0]  result;

  assign start_ok  = start && (state == ST_IDLE) && !abort;
  assign accept    = (state == ST_WAIT) && conv_done && !abort;
  assign next_iter = accept && !is_last;
  assign retry_go  = (state == ST_EVAL) && (mode_q == CMP_RETRY) && !hit;
  assign do_store  = (state == ST_EVAL) && (!mode_q[1] || hit);
  assign finish    = (state == ST_EVAL) && !retry_go;
  assign tmr_load  = start_ok || next_iter || retry_go;
  assign tmr_code  = start_ok ? stime_code : st_q;
  assign acc_clr   = abort || start_ok || retry_go;

  avgw_sample_timer #(.CODE_W(STIME_W), .CNT_W(TCNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .stop(abort),
    .code(tmr_code), .active(sample_phase), .last_cycle(tmr_last));

  avgw_accum #(.DATA_W(DATA_W), .CODE_W(AVG_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(accept),
    .din(conv_data), .code(avg_q), .is_last(is_last), .avg_out(result));

  avgw_window #(.DATA_W(DATA_W)) u_window (
    .value(result), .lo(lo_q), .hi(hi_q), .hit(hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q  <= '0;
      st_q   <= '0;
      mode_q <= CMP_OFF;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (start_ok) begin
      avg_q  <= avg_code;
      st_q   <= stime_code;
      mode_q <= cmp_mode_e'(cmp_mode);
      lo_q   <= lim_lo;
      hi_q   <= lim_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else if (abort) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:   if (start_ok) state <= ST_SAMPLE;
        ST_SAMPLE: if (tmr_last) state <= ST_WAIT;
        ST_WAIT:   if (accept) state <= is_last ? ST_EVAL : ST_SAMPLE;
        ST_EVAL:   state <= retry_go ? ST_SAMPLE : ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_vld  <= 1'b0;
      store_data <= '0;
      reacq_req  <= 1'b0;
      cmd_done   <= 1'b0;
    end else begin
      store_vld <= do_store && !abort;
      reacq_req <= retry_go && !abort;
      cmd_done  <= finish && !abort;
      if (do_store && !abort) store_data <= result;
    end
  end

  // R4 / R5: a store in a comparing mode always lies inside the window
  a_r4_store_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    store_vld && mode_q[1] |-> (store_data >= lo_q) && (store_data <= hi_q));
  // R5: a retry request excludes storing and finishing
  a_r5_retry_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    reacq_req |-> !store_vld && !cmd_done);
  // R3: with compare off, finishing always comes with a store
  a_r3_done_with_store: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done && !mode_q[1] |-> store_vld);
  // R8: abort silences every output on the following cycle
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !sample_phase && !store_vld && !cmd_done && !reacq_req);
endmodule

// File: tb/sim_avg_window_unit.sv
`timescale 1ns/1ps
module sim_avg_window_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0, abort = 0, conv_done = 0;
  logic [2:0]  avg_code = 0, stime_code = 0;
  logic [1:0]  cmp_mode = 0;
  logic [15:0] lim_lo = 0, lim_hi = 0, conv_data = 0;
  logic        sample_phase, store_vld, reacq_req, cmd_done;
  logic [15:0] store_data;

  int n_checks = 0, n_errors = 0;
  int n_store = 0, n_done = 0, n_reacq = 0;
  logic [15:0] last_data = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  avg_window_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .avg_code(avg_code), .stime_code(stime_code), .cmp_mode(cmp_mode),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .conv_done(conv_done), .conv_data(conv_data),
    .sample_phase(sample_phase), .store_vld(store_vld), .store_data(store_data),
    .reacq_req(reacq_req), .cmd_done(cmd_done));

  always @(negedge clk) if (rst_n) begin
    if (store_vld) begin n_store++; last_data = store_data; end
    if (cmd_done)  n_done++;
    if (reacq_req) n_reacq++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input [2:0] a, input [2:0] s, input [1:0] m,
                          input [15:0] lo, input [15:0] hi);
    @(negedge clk);
    avg_code = a; stime_code = s; cmp_mode = m; lim_lo = lo; lim_hi = hi;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // waits for a sample phase, measures it, then returns one conversion
  task automatic convert(input [15:0] d, output int len);
    len = 0;
    while (!sample_phase) @(negedge clk);
    while (sample_phase) begin len++; @(negedge clk); end
    conv_done = 1; conv_data = d;
    @(negedge clk);
    conv_done = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  function automatic int exp_len(input int c);
    case (c)
      0: return 3;   1: return 5;   2: return 7;   3: return 11;
      4: return 19;  5: return 35;  6: return 67;  default: return 131;
    endcase
  endfunction

  task automatic t_reset();
    #1;
    chk("reset sample_phase", sample_phase, 0);
    chk("reset store_vld", store_vld, 0);
    chk("reset cmd_done", cmd_done, 0);
    chk("reset reacq_req", reacq_req, 0);
  endtask

  task automatic t_sample_times();
    int len;
    for (int c = 0; c < 8; c++) begin
      do_start(3'd0, 3'(c), 2'b00, 16'd0, 16'd0);
      convert(16'd1, len);
      chk($sformatf("R7 sample length code %0d", c), len, exp_len(c));
      settle();
    end
  endtask

  task automatic t_average(input int n, input int base, input int step);
    int len, cnt = 1 << n;
    longint sum = 0;
    int st0 = n_store, d0 = n_done;
    do_start(3'(n), 3'd0, 2'b00, 16'd0, 16'd0);
    for (int i = 0; i < cnt; i++) begin
      int v = (base + i * step) & 16'hFFFF;
      sum += v;
      if (i == cnt - 1) begin
        #1;
        chk($sformatf("R1 no done before last of %0d", cnt), n_done - d0, 0);
      end
      convert(16'(v), len);
    end
    settle();
    chk($sformatf("R2 one store for code %0d", n), n_store - st0, 1);
    chk($sformatf("R2 average code %0d", n), last_data, 32'(sum / cnt));
    chk($sformatf("R3 done with store code %0d", n), n_done - d0, 1);
  endtask

  task automatic t_filter();
    int len;
    int vals[4] = '{100, 200, 99, 201};
    int want[4] = '{1, 1, 0, 0};
    for (int k = 0; k < 4; k++) begin
      int st0 = n_store, d0 = n_done;
      do_start(3'd0, 3'd0, 2'b10, 16'd100, 16'd200);
      convert(16'(vals[k]), len);
      settle();
      chk($sformatf("R4 stored? value %0d", vals[k]), n_store - st0, want[k]);
      chk($sformatf("R4 done value %0d", vals[k]), n_done - d0, 1);
      if (want[k] == 1) chk("R4 stored data", last_data, vals[k]);
    end
  endtask

  task automatic t_retry();
    int len;
    int st0 = n_store, d0 = n_done, r0 = n_reacq;
    do_start(3'd1, 3'd1, 2'b11, 16'd500, 16'd600);
    convert(16'd10, len);
    convert(16'd20, len);
    settle();
    chk("R5 reacq after miss", n_reacq - r0, 1);
    chk("R5 no store after miss", n_store - st0, 0);
    chk("R5 no done after miss", n_done - d0, 0);
    convert(16'd540, len);
    convert(16'd560, len);
    settle();
    chk("R5 store after hit", n_store - st0, 1);
    chk("R5 fresh accumulator result", last_data, 550);
    chk("R5 done after hit", n_done - d0, 1);
    chk("R5 single reacq", n_reacq - r0, 1);
  endtask

  task automatic t_reserved();
    int len;
    int st0 = n_store;
    do_start(3'd0, 3'd0, 2'b01, 16'd0, 16'd0);
    convert(16'd5, len);
    settle();
    chk("R6 reserved mode stores", n_store - st0, 1);
    chk("R6 reserved mode data", last_data, 5);
  endtask

  task automatic t_ignore();
    int len;
    int st0 = n_store, d0 = n_done;
    @(negedge clk);
    conv_done = 1; conv_data = 16'hFFFF;
    @(negedge clk);
    conv_done = 0;
    settle();
    chk("R9 idle strobe no store", n_store - st0, 0);
    chk("R9 idle strobe no done", n_done - d0, 0);
    do_start(3'd1, 3'd2, 2'b00, 16'd0, 16'd0);
    while (!sample_phase) @(negedge clk);
    conv_done = 1; conv_data = 16'hFFFF;
    @(negedge clk);
    conv_done = 0;
    convert(16'd100, len);
    convert(16'd300, len);
    settle();
    chk("R9 sample-phase strobe ignored", last_data, 200);
    chk("R9 one store", n_store - st0, 1);
  endtask

  task automatic t_abort();
    int len;
    int st0 = n_store, d0 = n_done, r0 = n_reacq;
    do_start(3'd2, 3'd1, 2'b00, 16'd0, 16'd0);
    convert(16'd1000, len);
    convert(16'd1000, len);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk("R8 sample phase dropped", sample_phase, 0);
    conv_done = 1; conv_data = 16'd1000;
    @(negedge clk);
    conv_done = 0;
    repeat (20) @(negedge clk);
    #1;
    chk("R8 no store after abort", n_store - st0, 0);
    chk("R8 no done after abort", n_done - d0, 0);
    chk("R8 no reacq after abort", n_reacq - r0, 0);
    do_start(3'd1, 3'd0, 2'b00, 16'd0, 16'd0);
    convert(16'd10, len);
    convert(16'd20, len);
    settle();
    chk("R8 fresh command result", last_data, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_sample_times();
    t_average(0, 1234, 0);
    t_average(3, 100, 13);
    t_average(7, 16'hFF00, 1);
    t_filter();
    t_retry();
    t_reserved();
    t_ignore();
    t_abort();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule